// File: doc/BRIEF.md
# Interrupt Gate Descriptor Checker

This block validates the path from an interrupt vector to its handler before any state is changed. A request carries the vector number, whether the interrupt was raised by software, the byte limit of the interrupt table, the current privilege level and the table format: 8-byte legacy entries or 16-byte 64-bit entries. The checker first tests that the entry lies inside the table. It then fetches the gate entry, and the descriptor of the code segment the gate points at, through a simple request/valid fetch port. It runs its checks in a fixed priority order.

Each run ends with a one-cycle `done` pulse. The result is either the first fault found, given as a kind plus a 16-bit error code, or a success. A success gives the handler selector and offset, whether the handler runs at an inner privilege level (which needs a stack switch), and the set of flags the entry sequence must clear. Task gates are recognised and passed on to a separate task-switch unit without a code-segment fetch.

Top module: `gate_check`

## Requirements
- R1: After reset `done`, `busy` and `fetchReq` are all low. `fetchReq` is never high while `busy` is low.
- R2: The entry end is vector*8+7 (legacy) or vector*16+15 (64-bit). If it exceeds `tableLimit`, the run ends with kind GP and error code vector*8+2 (legacy) or vector*16+2 (64-bit), and no fetch is made. Fault kinds are encoded 0 none, 1 GP, 2 NP; code 3 is never produced.
- R3: The gate word is laid out as offset[15:0] in bits 15:0, selector in 31:16, stack index in 34:32, type in 43:40, segment flag in 44 (must be 0 for a gate), privilege in 46:45, present in 47 and offset[31:16] in 63:48. Types 5, 6, 7, 14 and 15 are accepted in legacy mode and only 14 and 15 in 64-bit mode. Any other type, or a segment flag of 1, gives GP with code vector*8+2.
- R4: For a software interrupt, a gate privilege numerically below `curPriv` gives GP with code vector*8+2. For a hardware interrupt the gate privilege is not checked.
- R5: A gate with present bit 0 gives NP with code vector*8+2.
- R6: A non-task gate whose selector has bits 15:2 all zero gives GP with code 0, and no code-segment fetch is made.
- R7: The code-segment word has the conforming bit at 42, executable at 43, segment flag at 44, privilege at 46:45 and present at 47. A segment flag of 0, executable of 0, or privilege above `curPriv` gives GP with the selector's low two bits cleared.
- R8: A code segment that passes R7 but is not present gives NP with the masked selector.
- R9: Checks run in the order R2, R3, R4, R5, R6, R7, R8, and only the first failure is reported.
- R10: On success `innerPriv` is 1 when the target is non-conforming with privilege below `curPriv`, or in 64-bit mode when the gate's stack index is nonzero.
- R11: `clrMask` bit 0 is interrupt enable, bit 1 trap, bit 2 virtual-8086, bit 3 resume and bit 4 nested task. On success bits 4:1 are set, and bit 0 is set only for even gate types. On a fault the mask and `innerPriv` are zero.
- R12: On success `targetSel` is the gate's raw selector. `targetOff` is the full 32-bit gate offset for types 14/15, and the low 16 bits zero-extended for types 6/7.
- R13: A legacy task gate (type 5) that passes R3 to R5 succeeds right after the gate fetch. It sets `taskGate`, returns its selector, gives a zero offset and mask, and clears `innerPriv`.
- R14: `fetchReq` and `fetchAddr` are held until `fetchValid`. The first fetch address is the entry's byte offset (vector*8 or vector*16). The second is the selector with its low two bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; taken only when idle |
| vecIn | input | 8 | Interrupt vector number |
| swInt | input | 1 | Interrupt raised by software |
| tableLimit | input | 16 | Interrupt table byte limit |
| curPriv | input | 2 | Current privilege level |
| longMode | input | 1 | 1 selects 16-byte 64-bit entries |
| fetchReq | output | 1 | Descriptor fetch request |
| fetchAddr | output | 16 | Table offset or masked selector to fetch |
| fetchValid | input | 1 | Fetched word is valid |
| fetchData | input | 64 | Fetched descriptor word |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| faultKind | output | 2 | 0 none, 1 GP, 2 NP |
| errCode | output | 16 | Fault error code |
| targetSel | output | 16 | Handler code selector |
| targetOff | output | 32 | Handler offset |
| innerPriv | output | 1 | Handler needs a stack switch |
| clrMask | output | 5 | Flags to clear on entry |
| taskGate | output | 1 | Gate is a task gate |

## Verification
The bench probes the limit compare at the exact last legal byte in both table formats. An off-by-one compare would accept or reject an entry one byte too early, and a wrong scale would report the wrong error code. It pairs failures that hit together, such as a bad type with a missing present bit, or a too-privileged target that is also absent. An implementation with the checks in the wrong order would report NP where GP is due. It separates 16-bit from 32-bit gate offsets and tests the stack-index rule in both modes, so a design that switches stacks in legacy mode or fails to truncate a 16-bit gate's offset gives a wrong result. It also holds back `fetchValid` for several cycles, which would expose a request that drops or an address that moves while waiting.

// File: rtl/gate_chk_pkg.sv
package gate_chk_pkg;
  typedef enum logic [1:0] {FK_NONE = 2'd0, FK_GP = 2'd1, FK_NP = 2'd2, FK_SS = 2'd3} fault_e;
  typedef enum logic [1:0] {STG_LIMIT = 2'd0, STG_GATE = 2'd1, STG_SEG = 2'd2} stage_e;

  typedef struct packed {
    logic   capture;
    logic   loadGate;
    logic   loadSeg;
    logic   finish;
    logic   addrSeg;
    stage_e stage;
  } ctrl_t;

  localparam int DESC_W = 64;
  localparam int SEL_W  = 16;
  localparam int OFF_W  = 32;
  localparam int ERR_W  = 16;
  localparam int MASK_W = 5;
endpackage

// File: rtl/gate_chk_ctrl.sv
module gate_chk_ctrl
  import gate_chk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  fetchValid,
  input  logic  stageFail,
  input  logic  isTask,
  output ctrl_t ctl,
  output logic  fetchReq,
  output logic  busy
);
  typedef enum logic [2:0] {S_IDLE, S_LIM, S_FGATE, S_CGATE, S_FSEG, S_CSEG} state_e;
  state_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    ctl.stage = STG_LIMIT;
    fetchReq  = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        ctl.capture = start;
        if (start) nextState = S_LIM;
      end
      S_LIM: begin
        ctl.stage = STG_LIMIT;
        if (stageFail) begin
          ctl.finish = 1'b1;
          nextState  = S_IDLE;
        end else begin
          nextState = S_FGATE;
        end
      end
      S_FGATE: begin
        fetchReq = 1'b1;
        if (fetchValid) begin
          ctl.loadGate = 1'b1;
          nextState    = S_CGATE;
        end
      end
      S_CGATE: begin
        ctl.stage = STG_GATE;
        if (stageFail || isTask) begin
          ctl.finish = 1'b1;
          nextState  = S_IDLE;
        end else begin
          nextState = S_FSEG;
        end
      end
      S_FSEG: begin
        fetchReq    = 1'b1;
        ctl.addrSeg = 1'b1;
        if (fetchValid) begin
          ctl.loadSeg = 1'b1;
          nextState   = S_CSEG;
        end
      end
      S_CSEG: begin
        ctl.stage  = STG_SEG;
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/gate_chk_dp.sv
module gate_chk_dp
  import gate_chk_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctl,
  input  logic [VEC_W-1:0]   vecIn,
  input  logic               swInt,
  input  logic [LIM_W-1:0]   tableLimit,
  input  logic [1:0]         curPriv,
  input  logic               longMode,
  input  logic [DESC_W-1:0]  fetchData,
  output logic               stageFail,
  output logic               isTask,
  output logic [ERR_W-1:0]   fetchAddr,
  output logic               done,
  output fault_e             faultKind,
  output logic [ERR_W-1:0]   errCode,
  output logic [SEL_W-1:0]   targetSel,
  output logic [OFF_W-1:0]   targetOff,
  output logic               innerPriv,
  output logic [MASK_W-1:0]  clrMask,
  output logic               taskGate
);
  logic [VEC_W-1:0] vecR;
  logic [LIM_W-1:0] limR;
  logic [1:0]       cplR;
  logic             swR, longR;

  logic [OFF_W-1:0] gOff;
  logic [SEL_W-1:0] gSel;
  logic [2:0]       gIst;
  logic [3:0]       gType;
  logic             gSegFlag, gPres;
  logic [1:0]       gDpl;
  logic             sConf, sExec, sSegFlag, sPres;
  logic [1:0]       sDpl;
  logic             unusedRsvd;

  assign unusedRsvd = ^fetchData[39:35];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecR <= '0; limR <= '0; cplR <= '0; swR <= 1'b0; longR <= 1'b0;
      gOff <= '0; gSel <= '0; gIst <= '0; gType <= '0;
      gSegFlag <= 1'b0; gPres <= 1'b0; gDpl <= '0;
      sConf <= 1'b0; sExec <= 1'b0; sSegFlag <= 1'b0; sPres <= 1'b0; sDpl <= '0;
    end else begin
      if (ctl.capture) begin
        vecR <= vecIn; limR <= tableLimit; cplR <= curPriv;
        swR <= swInt; longR <= longMode;
      end
      if (ctl.loadGate) begin
        gOff     <= {fetchData[63:48], fetchData[15:0]};
        gSel     <= fetchData[31:16];
        gIst     <= fetchData[34:32];
        gType    <= fetchData[43:40];
        gSegFlag <= fetchData[44];
        gDpl     <= fetchData[46:45];
        gPres    <= fetchData[47];
      end
      if (ctl.loadSeg) begin
        sConf    <= fetchData[42];
        sExec    <= fetchData[43];
        sSegFlag <= fetchData[44];
        sDpl     <= fetchData[46:45];
        sPres    <= fetchData[47];
      end
    end
  end

  // Derived offsets and codes
  logic [31:0]      entryBase, entryEnd;
  logic             limFail, typeOk;
  logic [ERR_W-1:0] limErr, gateErr, selMasked;

  always_comb begin
    entryBase = longR ? (32'(vecR) << 4) : (32'(vecR) << 3);
    entryEnd  = entryBase + (longR ? 32'd15 : 32'd7);
    limFail   = entryEnd > 32'(limR);
    limErr    = ERR_W'(entryBase + 32'd2);
    gateErr   = ERR_W'((32'(vecR) << 3) + 32'd2);
    selMasked = {gSel[SEL_W-1:2], 2'b00};
    case (gType)
      4'd14, 4'd15:      typeOk = !gSegFlag;
      4'd5, 4'd6, 4'd7:  typeOk = !gSegFlag && !longR;
      default:           typeOk = 1'b0;
    endcase
  end

  assign isTask    = (gType == 4'd5);
  assign fetchAddr = ctl.addrSeg ? selMasked : ERR_W'(entryBase);

  fault_e           oKind;
  logic [ERR_W-1:0] oCode;

  always_comb begin
    oKind = FK_NONE;
    oCode = '0;
    case (ctl.stage)
      STG_LIMIT: begin
        if (limFail) begin oKind = FK_GP; oCode = limErr; end
      end
      STG_GATE: begin
        if (!typeOk)                  begin oKind = FK_GP; oCode = gateErr; end
        else if (swR && gDpl < cplR)  begin oKind = FK_GP; oCode = gateErr; end
        else if (!gPres)              begin oKind = FK_NP; oCode = gateErr; end
        else if (!isTask && gSel[SEL_W-1:2] == '0) begin oKind = FK_GP; oCode = '0; end
      end
      STG_SEG: begin
        if (!sSegFlag || !sExec || sDpl > cplR) begin oKind = FK_GP; oCode = selMasked; end
        else if (!sPres)                        begin oKind = FK_NP; oCode = selMasked; end
      end
      default: ;
    endcase
  end

  assign stageFail = (oKind != FK_NONE);

  logic             okInner;
  logic [OFF_W-1:0] okOff;
  logic [MASK_W-1:0] okMask;

  always_comb begin
    if (isTask) begin
      okInner = 1'b0;
      okOff   = '0;
      okMask  = '0;
    end else begin
      okInner = (!sConf && sDpl < cplR) || (longR && gIst != 3'd0);
      okOff   = gType[3] ? gOff : {16'h0, gOff[15:0]};
      okMask  = {4'b1111, ~gType[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; faultKind <= FK_NONE; errCode <= '0; targetSel <= '0;
      targetOff <= '0; innerPriv <= 1'b0; clrMask <= '0; taskGate <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        faultKind <= oKind;
        errCode   <= oCode;
        if (stageFail) begin
          targetSel <= '0; targetOff <= '0; innerPriv <= 1'b0;
          clrMask <= '0; taskGate <= 1'b0;
        end else begin
          targetSel <= gSel; targetOff <= okOff; innerPriv <= okInner;
          clrMask <= okMask; taskGate <= isTask;
        end
      end
    end
  end
endmodule

// File: rtl/gate_check.sv
module gate_check
  import gate_chk_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vecIn,
  input  logic              swInt,
  input  logic [LIM_W-1:0]  tableLimit,
  input  logic [1:0]        curPriv,
  input  logic              longMode,
  output logic              fetchReq,
  output logic [15:0]       fetchAddr,
  input  logic              fetchValid,
  input  logic [63:0]       fetchData,
  output logic              busy,
  output logic              done,
  output logic [1:0]        faultKind,
  output logic [15:0]       errCode,
  output logic [15:0]       targetSel,
  output logic [31:0]       targetOff,
  output logic              innerPriv,
  output logic [4:0]        clrMask,
  output logic              taskGate
);
  ctrl_t  ctl;
  logic   stageFail, isTask;
  fault_e kindInt;

  gate_chk_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fetchValid(fetchValid),
    .stageFail(stageFail), .isTask(isTask), .ctl(ctl),
    .fetchReq(fetchReq), .busy(busy)
  );

  gate_chk_dp #(.VEC_W(VEC_W), .LIM_W(LIM_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .vecIn(vecIn), .swInt(swInt),
    .tableLimit(tableLimit), .curPriv(curPriv), .longMode(longMode),
    .fetchData(fetchData), .stageFail(stageFail), .isTask(isTask),
    .fetchAddr(fetchAddr), .done(done), .faultKind(kindInt), .errCode(errCode),
    .targetSel(targetSel), .targetOff(targetOff), .innerPriv(innerPriv),
    .clrMask(clrMask), .taskGate(taskGate)
  );

  assign faultKind = kindInt;
endmodule

// File: rtl/gate_check_sva.sv
module gate_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        fetchReq,
  input logic        fetchValid,
  input logic [15:0] fetchAddr,
  input logic        busy,
  input logic        done,
  input logic [1:0]  faultKind,
  input logic [4:0]  clrMask,
  input logic        innerPriv,
  input logic        taskGate
);
  // R1
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fetchReq);

  // R14
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq && !fetchValid |=> fetchReq && $stable(fetchAddr));

  // R2
  kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> faultKind != 2'd3);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  fault_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && faultKind != 2'd0 |-> clrMask == 5'd0 && !innerPriv);

  // R11
  ok_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && faultKind == 2'd0 && !taskGate |-> clrMask[4:1] == 4'hF);

  // R13
  task_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && taskGate |-> clrMask == 5'd0 && faultKind == 2'd0 && !innerPriv);
endmodule

bind gate_check gate_check_sva sva_i (
  .clk(clk), .rst_n(rst_n), .fetchReq(fetchReq), .fetchValid(fetchValid),
  .fetchAddr(fetchAddr), .busy(busy), .done(done), .faultKind(faultKind),
  .clrMask(clrMask), .innerPriv(innerPriv), .taskGate(taskGate)
);

// File: tb/gate_check_tb_top.sv
`timescale 1ns/1ps
module gate_check_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vecIn = '0;
  logic        swInt = 1'b0;
  logic [15:0] tableLimit = '0;
  logic [1:0]  curPriv = '0;
  logic        longMode = 1'b0;
  logic        fetchReq;
  logic [15:0] fetchAddr;
  logic        fetchValid = 1'b0;
  logic [63:0] fetchData = '0;
  logic        busy, done, innerPriv, taskGate;
  logic [1:0]  faultKind;
  logic [15:0] errCode, targetSel;
  logic [31:0] targetOff;
  logic [4:0]  clrMask;

  always #2.5 clk = ~clk;

  gate_check dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vecIn(vecIn), .swInt(swInt),
    .tableLimit(tableLimit), .curPriv(curPriv), .longMode(longMode),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchValid(fetchValid),
    .fetchData(fetchData), .busy(busy), .done(done), .faultKind(faultKind),
    .errCode(errCode), .targetSel(targetSel), .targetOff(targetOff),
    .innerPriv(innerPriv), .clrMask(clrMask), .taskGate(taskGate)
  );

  int checks = 0;
  int fails  = 0;

  logic [1:0]  rKind;
  logic [15:0] rCode, rSel;
  logic [31:0] rOff;
  logic        rInner, rTask, holdOk;
  logic [4:0]  rMask;
  int          nFetch;
  logic [15:0] fAddr0, fAddr1;

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkGate(input logic [31:0] off, input logic [15:0] sel,
      input logic [2:0] ist, input logic [3:0] typ, input logic seg,
      input logic [1:0] dpl, input logic p);
    return {off[31:16], p, dpl, seg, typ, 5'b0, ist, sel, off[15:0]};
  endfunction

  function automatic logic [63:0] mkSeg(input logic exec, input logic conf, input logic seg,
      input logic [1:0] dpl, input logic p);
    return {16'h0, p, dpl, seg, exec, conf, 2'b00, 40'h0};
  endfunction

  task automatic runCase(input logic lm, input logic [7:0] v, input logic sw,
      input logic [15:0] lim, input logic [1:0] cpl, input logic [63:0] gw,
      input logic [63:0] segw, input int delay);
    bit fin;
    logic [15:0] a0;
    @(negedge clk);
    longMode = lm; vecIn = v; swInt = sw; tableLimit = lim; curPriv = cpl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nFetch = 0; holdOk = 1'b1; fin = 1'b0; fAddr0 = '0; fAddr1 = '0;
    for (int cyc = 0; cyc < 64 && !fin; cyc++) begin
      if (done) begin
        rKind = faultKind; rCode = errCode; rSel = targetSel; rOff = targetOff;
        rInner = innerPriv; rMask = clrMask; rTask = taskGate;
        fin = 1'b1;
      end else if (fetchReq) begin
        a0 = fetchAddr;
        if (nFetch == 0) fAddr0 = a0; else fAddr1 = a0;
        for (int d = 0; d < delay; d++) begin
          @(negedge clk);
          if (!fetchReq || fetchAddr !== a0) holdOk = 1'b0;
        end
        fetchData  = (nFetch == 0) ? gw : segw;
        fetchValid = 1'b1;
        nFetch++;
        @(negedge clk);
        fetchValid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    if (!fin) chkEq("R1 run did not complete", 0, 1);
  endtask

  task automatic expFault(input string req, input logic [1:0] kind, input logic [15:0] code,
      input int nf);
    chkEq({req, " kind"}, rKind, kind);
    chkEq({req, " code"}, rCode, code);
    chkEq({req, " fetches"}, nFetch, nf);
    chkEq({req, " R11 mask zero"}, {rInner, rMask}, 0);
  endtask

  task automatic expOk(input string req, input logic [15:0] sel, input logic [31:0] off,
      input logic inner, input logic [4:0] mask, input logic tsk, input int nf);
    chkEq({req, " kind"}, rKind, 0);
    chkEq({req, " R12 sel"}, rSel, sel);
    chkEq({req, " R12 off"}, rOff, off);
    chkEq({req, " R10 inner"}, rInner, inner);
    chkEq({req, " R11 mask"}, rMask, mask);
    chkEq({req, " R13 task"}, rTask, tsk);
    chkEq({req, " fetches"}, nFetch, nf);
  endtask

  localparam logic [1:0] K_GP = 2'd1;
  localparam logic [1:0] K_NP = 2'd2;

  // vector 0x21: *8 = 0x108, *16 = 0x210
  task automatic tResetState();
    chkEq("R1 done", done, 0);
    chkEq("R1 busy", busy, 0);
    chkEq("R1 fetchReq", fetchReq, 0);
  endtask

  task automatic tLegacyInner();
    runCase(0, 8'h21, 0, 16'h07FF, 2'd3, mkGate(32'h12345678, 16'h0013, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expOk("R10 legacy int gate inner", 16'h0013, 32'h12345678, 1, 5'b11111, 0, 2);
    chkEq("R14 gate addr", fAddr0, 16'h0108);
    chkEq("R14 seg addr", fAddr1, 16'h0010);
  endtask

  task automatic tTrapConforming();
    runCase(0, 8'h21, 0, 16'h07FF, 2'd2, mkGate(32'hCAFE0042, 16'h0018, 3'd0, 4'd15, 0, 2'd0, 1),
            mkSeg(1, 1, 1, 2'd0, 1), 0);
    expOk("R11 trap gate conforming", 16'h0018, 32'hCAFE0042, 0, 5'b11110, 0, 2);
  endtask

  task automatic tNarrowGate();
    runCase(0, 8'h21, 0, 16'h07FF, 2'd0, mkGate(32'h12345678, 16'h0008, 3'd0, 4'd6, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expOk("R12 16-bit gate offset", 16'h0008, 32'h00005678, 0, 5'b11111, 0, 2);
  endtask

  task automatic tLimits();
    runCase(0, 8'h21, 0, 16'h010F, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expOk("R2 legacy last byte fits", 16'h0008, 32'h100, 0, 5'b11111, 0, 2);
    runCase(0, 8'h21, 0, 16'h010E, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R2 legacy limit", K_GP, 16'h010A, 0);
    runCase(1, 8'h21, 0, 16'h021F, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expOk("R2 64-bit last byte fits", 16'h0008, 32'h100, 0, 5'b11111, 0, 2);
    runCase(1, 8'h21, 0, 16'h021E, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R2 64-bit limit", K_GP, 16'h0212, 0);
  endtask

  task automatic tTypes();
    runCase(1, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd6, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R3 64-bit rejects type 6", K_GP, 16'h010A, 1);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd12, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R3 legacy rejects type 12", K_GP, 16'h010A, 1);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 1, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R3 segment flag set", K_GP, 16'h010A, 1);
  endtask

  task automatic tSoftware();
    runCase(0, 8'h21, 1, 16'hFFFF, 2'd3, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R4 software gate privilege", K_GP, 16'h010A, 1);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd3, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expOk("R4 hardware skips gate privilege", 16'h0008, 32'h100, 1, 5'b11111, 0, 2);
  endtask

  task automatic tGateAbsent();
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd14, 0, 2'd0, 0),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R5 gate not present", K_NP, 16'h010A, 1);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h0008, 3'd0, 4'd9, 0, 2'd0, 0),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R9 bad type before absent", K_GP, 16'h010A, 1);
  endtask

  task automatic tNullSel();
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h0003, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expFault("R6 null selector", K_GP, 16'h0000, 1);
  endtask

  task automatic tSegChecks();
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h002B, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd3, 1), 0);
    expFault("R7 target privilege too low", K_GP, 16'h0028, 2);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h002B, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(0, 0, 1, 2'd0, 1), 0);
    expFault("R7 target not executable", K_GP, 16'h0028, 2);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h002B, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 0), 0);
    expFault("R8 target not present", K_NP, 16'h0028, 2);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h100, 16'h002B, 3'd0, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd2, 0), 0);
    expFault("R9 privilege before presence", K_GP, 16'h0028, 2);
  endtask

  task automatic tStackIndex();
    runCase(1, 8'h21, 0, 16'hFFFF, 2'd1, mkGate(32'h100, 16'h0008, 3'd2, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 1, 1, 2'd0, 1), 0);
    expOk("R10 64-bit stack index", 16'h0008, 32'h100, 1, 5'b11111, 0, 2);
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd1, mkGate(32'h100, 16'h0008, 3'd2, 4'd14, 0, 2'd0, 1),
            mkSeg(1, 1, 1, 2'd0, 1), 0);
    expOk("R10 legacy ignores stack index", 16'h0008, 32'h100, 0, 5'b11111, 0, 2);
  endtask

  task automatic tTask();
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd0, mkGate(32'h5555, 16'h0028, 3'd0, 4'd5, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 0);
    expOk("R13 task gate", 16'h0028, 32'h0, 0, 5'b00000, 1, 1);
  endtask

  task automatic tSlowFetch();
    runCase(0, 8'h21, 0, 16'hFFFF, 2'd3, mkGate(32'h0BEEF000, 16'h0013, 3'd0, 4'd15, 0, 2'd0, 1),
            mkSeg(1, 0, 1, 2'd0, 1), 3);
    chkEq("R14 request held stable", holdOk, 1);
    expOk("R14 slow fetch result", 16'h0013, 32'h0BEEF000, 1, 5'b11110, 0, 2);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rst_n = 1'b1;
    @(negedge clk);
    tResetState();
    tLegacyInner();
    tTrapConforming();
    tNarrowGate();
    tLimits();
    tTypes();
    tSoftware();
    tGateAbsent();
    tNullSel();
    tSegChecks();
    tStackIndex();
    tTask();
    tSlowFetch();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule